// File: doc/BRIEF.md
# Predicate Lookup Unit

This block works out the per-element enable mask, and whether disabled elements must be cleared, for one vectorised operation. A request names a register and says whether the operation runs on the integer or the floating-point file. The block looks up two configuration entries for that register. The first is the register-table entry, which holds an active bit. The second is the predicate-table entry, which holds an enable bit, an invert bit, a zeroing bit and an index into the integer register file. If predication applies, the mask is read from the integer register that the index names, and it is inverted when the invert bit asks for it. In every other case, all elements run and no zeroing takes place.

Branch comparisons use a relaxed rule. The register-table active bit is not required, and only the predicate entry's enable bit decides. A compressed branch has a single source register, so it always takes its predicate target from the entry of register 0, whatever register number comes with the request. The tables arrive as plain configuration vectors. The integer register file is reached through one combinational read port.

The lookup is combinational. Requests and responses use valid/ready. The response is valid in the same cycle as the request, and it stays valid while the request is held. Back-pressure passes straight through: `req_ready` follows `rsp_ready`. A request counts as taken only in a cycle where `req_valid` and `rsp_ready` are both high. The requester must hold its fields stable until then, and the response fields stay stable with them.

Top module: `pred_lookup_unit`

## Requirements
- R1: When `req_is_fp` is 0, the integer register table (`itab_active`) and the integer predicate table (`ipred_*`) are used. When it is 1, the floating-point tables (`ftab_active`, `fpred_*`) are used. The entry for register k sits at bit k of each one-bit vector and at bits [k*5 +: 5] of the index vector.
- R2: Outside branch modes, if the selected register-table active bit is 0, `rsp_mask` is all ones and `rsp_zero` is 0, whatever the predicate entry holds.
- R3: If the register-table bit is 1 but the predicate enable bit is 0, `rsp_mask` is all ones and `rsp_zero` is 0.
- R4: When predication applies, `rf_raddr` equals the predicate entry's index field and `rsp_mask` equals `rf_rdata`, in the same cycle.
- R5: When predication applies and the invert bit is 1, `rsp_mask` is the bitwise complement of `rf_rdata`.
- R6: When predication applies, `rsp_zero` equals the entry's zeroing bit. Otherwise it is 0.
- R7: With `req_branch` at 1, the register-table active bit is ignored, and predication applies exactly when the predicate enable bit is 1.
- R8: With `req_cbranch` at 1, the lookup ignores `req_reg` and uses register 0's entry in the selected predicate table, with the branch rule of R7.
- R9: `rsp_valid` equals `req_valid` and `req_ready` equals `rsp_ready` in every cycle. In reset with no request, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, sampled only by the bound checks |
| rst_n | input | 1 | Active-low reset for the bound checks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_reg | input | 5 | Register whose entries are looked up |
| req_is_fp | input | 1 | 1 selects the floating-point tables |
| req_branch | input | 1 | Branch rule: skip register-table check |
| req_cbranch | input | 1 | Compressed branch: use register 0's entry, branch rule |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_mask | output | 64 | Per-element enable mask |
| rsp_zero | output | 1 | Disabled elements must be cleared |
| itab_active | input | 32 | Integer register-table active bits |
| ftab_active | input | 32 | Floating-point register-table active bits |
| ipred_en | input | 32 | Integer predicate-table enable bits |
| ipred_inv | input | 32 | Integer predicate-table invert bits |
| ipred_zero | input | 32 | Integer predicate-table zeroing bits |
| ipred_idx | input | 160 | Integer predicate-table mask-register indices |
| fpred_en | input | 32 | Floating-point predicate-table enable bits |
| fpred_inv | input | 32 | Floating-point predicate-table invert bits |
| fpred_zero | input | 32 | Floating-point predicate-table zeroing bits |
| fpred_idx | input | 160 | Floating-point predicate-table mask-register indices |
| rf_raddr | output | 5 | Integer register file read address |
| rf_rdata | input | 64 | Integer register file read data |

## Verification
The directed cases set up each gating combination on its own:
- a register-table bit that is off while its predicate entry is on, which tells the two-level rule apart from a single check;
- a register-table bit that is on with its predicate entry off;
- both on, with and without inversion and zeroing.

Integer and floating-point requests use tables that disagree, so a swap between the two files shows up. Branch requests are paired with an inactive register-table bit, to show that the check is skipped. Compressed-branch requests name a register whose entry differs from register 0's, which exposes any lookup that does not force the index to 0. Random tables, register contents and modes then cover mixed cases against a bench model, and the handshake pins are toggled on their own.

// File: rtl/pred_lookup_pkg.sv
package pred_lookup_pkg;

  // Flags held by one predicate-table entry.
  typedef struct packed {
    logic en;
    logic inv;
    logic zero;
  } pl_flags_t;

  // Outcome of the gating decision.
  typedef enum logic {
    PL_OPEN       = 1'b0,
    PL_PREDICATED = 1'b1
  } pl_verdict_t;

endpackage

// File: rtl/pl_entry_pick.sv
module pl_entry_pick
  import pred_lookup_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IW   = 5
) (
  input  logic              sel_fp,
  input  logic [IW-1:0]     sel_idx,
  input  logic [NREG-1:0]   i_act,
  input  logic [NREG-1:0]   i_en,
  input  logic [NREG-1:0]   i_inv,
  input  logic [NREG-1:0]   i_zero,
  input  logic [NREG*IW-1:0] i_idx,
  input  logic [NREG-1:0]   f_act,
  input  logic [NREG-1:0]   f_en,
  input  logic [NREG-1:0]   f_inv,
  input  logic [NREG-1:0]   f_zero,
  input  logic [NREG*IW-1:0] f_idx,
  output logic              act,
  output pl_flags_t         flags,
  output logic [IW-1:0]     pidx
);

  localparam int NFILE = 2;

  logic [NREG-1:0] act_v [NFILE];
  pl_flags_t       fl    [NFILE][NREG];
  logic [IW-1:0]   ix    [NFILE][NREG];

  assign act_v[0] = i_act;
  assign act_v[1] = f_act;

  // Unpack both tables into per-entry views.
  for (genvar e = 0; e < NREG; e++) begin : g_entry
    assign fl[0][e] = '{en: i_en[e], inv: i_inv[e], zero: i_zero[e]};
    assign fl[1][e] = '{en: f_en[e], inv: f_inv[e], zero: f_zero[e]};
    assign ix[0][e] = i_idx[e*IW +: IW];
    assign ix[1][e] = f_idx[e*IW +: IW];
  end

  always_comb begin
    act   = act_v[sel_fp][sel_idx];
    flags = fl[sel_fp][sel_idx];
    pidx  = ix[sel_fp][sel_idx];
  end

endmodule

// File: rtl/pl_gate.sv
module pl_gate
  import pred_lookup_pkg::*;
(
  input  logic        reg_active,
  input  logic        pred_en,
  input  logic        skip_reg_check,
  output pl_verdict_t verdict
);

  // The register table is consulted first, and then the predicate entry.
  // Branch forms leave out the first stage.
  always_comb begin
    verdict = PL_OPEN;
    if (skip_reg_check || reg_active) begin
      if (pred_en) verdict = PL_PREDICATED;
    end
  end

endmodule

// File: rtl/pl_mask_form.sv
module pl_mask_form
  import pred_lookup_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  pl_verdict_t     verdict,
  input  logic            inv,
  input  logic            zero_bit,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] mask,
  output logic            zero_out
);

  always_comb begin
    if (verdict == PL_PREDICATED) begin
      mask     = inv ? ~rdata : rdata;
      zero_out = zero_bit;
    end else begin
      mask     = '1;
      zero_out = 1'b0;
    end
  end

endmodule

// File: rtl/pred_lookup_unit.sv
module pred_lookup_unit
  import pred_lookup_pkg::*;
#(
  parameter int NREG = 32,
  parameter int XLEN = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IW-1:0]      req_reg,
  input  logic               req_is_fp,
  input  logic               req_branch,
  input  logic               req_cbranch,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [XLEN-1:0]    rsp_mask,
  output logic               rsp_zero,
  input  logic [NREG-1:0]    itab_active,
  input  logic [NREG-1:0]    ftab_active,
  input  logic [NREG-1:0]    ipred_en,
  input  logic [NREG-1:0]    ipred_inv,
  input  logic [NREG-1:0]    ipred_zero,
  input  logic [NREG*IW-1:0] ipred_idx,
  input  logic [NREG-1:0]    fpred_en,
  input  logic [NREG-1:0]    fpred_inv,
  input  logic [NREG-1:0]    fpred_zero,
  input  logic [NREG*IW-1:0] fpred_idx,
  output logic [IW-1:0]      rf_raddr,
  input  logic [XLEN-1:0]    rf_rdata
);

  logic        [IW-1:0] eff_reg;
  logic                 skip_chk;
  logic                 sel_act;
  pl_flags_t            sel_flags;
  logic        [IW-1:0] sel_pidx;
  pl_verdict_t          verdict;

  // A compressed branch always takes its target from register 0's entry.
  assign eff_reg  = req_cbranch ? '0 : req_reg;
  assign skip_chk = req_branch | req_cbranch;

  // The lookup has no storage, so the handshake passes straight through.
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;

  pl_entry_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .sel_fp  (req_is_fp),
    .sel_idx (eff_reg),
    .i_act   (itab_active),
    .i_en    (ipred_en),
    .i_inv   (ipred_inv),
    .i_zero  (ipred_zero),
    .i_idx   (ipred_idx),
    .f_act   (ftab_active),
    .f_en    (fpred_en),
    .f_inv   (fpred_inv),
    .f_zero  (fpred_zero),
    .f_idx   (fpred_idx),
    .act     (sel_act),
    .flags   (sel_flags),
    .pidx    (sel_pidx)
  );

  assign rf_raddr = sel_pidx;

  pl_gate u_gate (
    .reg_active     (sel_act),
    .pred_en        (sel_flags.en),
    .skip_reg_check (skip_chk),
    .verdict        (verdict)
  );

  pl_mask_form #(.XLEN(XLEN)) u_form (
    .verdict  (verdict),
    .inv      (sel_flags.inv),
    .zero_bit (sel_flags.zero),
    .rdata    (rf_rdata),
    .mask     (rsp_mask),
    .zero_out (rsp_zero)
  );

endmodule

// File: rtl/pred_lookup_chk.sv
module pred_lookup_chk #(
  parameter int NREG = 32,
  parameter int XLEN = 64,
  localparam int IW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [IW-1:0]      req_reg,
  input logic               req_is_fp,
  input logic               req_branch,
  input logic               req_cbranch,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [XLEN-1:0]    rsp_mask,
  input logic               rsp_zero,
  input logic [NREG-1:0]    itab_active,
  input logic [NREG-1:0]    ftab_active,
  input logic [NREG-1:0]    ipred_en,
  input logic [NREG-1:0]    ipred_inv,
  input logic [NREG-1:0]    ipred_zero,
  input logic [NREG*IW-1:0] ipred_idx,
  input logic [NREG-1:0]    fpred_en,
  input logic [NREG-1:0]    fpred_inv,
  input logic [NREG-1:0]    fpred_zero,
  input logic [NREG*IW-1:0] fpred_idx,
  input logic [IW-1:0]      rf_raddr,
  input logic [XLEN-1:0]    rf_rdata
);

  logic [IW-1:0] k;
  logic          c_act, c_en, c_inv, c_zero, c_br;
  logic [IW-1:0] c_idx;

  assign k      = req_cbranch ? '0 : req_reg;
  assign c_br   = req_branch | req_cbranch;
  assign c_act  = req_is_fp ? ftab_active[k] : itab_active[k];
  assign c_en   = req_is_fp ? fpred_en[k]    : ipred_en[k];
  assign c_inv  = req_is_fp ? fpred_inv[k]   : ipred_inv[k];
  assign c_zero = req_is_fp ? fpred_zero[k]  : ipred_zero[k];
  assign c_idx  = req_is_fp ? fpred_idx[k*IW +: IW] : ipred_idx[k*IW +: IW];

  // R9
  a_r9_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == req_valid) && (req_ready == rsp_ready));

  // R2
  a_r2_reg_inactive_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !c_br && !c_act) |-> (&rsp_mask && !rsp_zero));

  // R3
  a_r3_pred_off_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !c_en) |-> (&rsp_mask && !rsp_zero));

  // R4 and R5
  a_r4_indirect_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && c_en && (c_act || c_br)) |->
      (rf_raddr == c_idx && rsp_mask == (c_inv ? ~rf_rdata : rf_rdata)));

  // R6
  a_r6_zero_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_zero) |-> (c_en && c_zero));

  // R8
  a_r8_cbranch_x0_target: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cbranch) |->
      (rf_raddr == (req_is_fp ? fpred_idx[IW-1:0] : ipred_idx[IW-1:0])));

endmodule

bind pred_lookup_unit pred_lookup_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (.*);

// File: tb/test_pred_lookup_unit.sv
module test_pred_lookup_unit;

  localparam int NREG = 32;
  localparam int XLEN = 64;
  localparam int IW   = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic               req_valid, req_ready, req_is_fp, req_branch, req_cbranch;
  logic [IW-1:0]      req_reg;
  logic               rsp_valid, rsp_ready, rsp_zero;
  logic [XLEN-1:0]    rsp_mask;
  logic [NREG-1:0]    itab_active, ftab_active;
  logic [NREG-1:0]    ipred_en, ipred_inv, ipred_zero;
  logic [NREG-1:0]    fpred_en, fpred_inv, fpred_zero;
  logic [NREG*IW-1:0] ipred_idx, fpred_idx;
  logic [IW-1:0]      rf_raddr;
  logic [XLEN-1:0]    rf_rdata;
  logic [XLEN-1:0]    rf [NREG];

  assign rf_rdata = rf[rf_raddr];

  int total = 0;
  int bad   = 0;

  pred_lookup_unit #(.NREG(NREG), .XLEN(XLEN)) i_pred_lookup_unit (.*);

  // Bench model built from the requirements.
  function automatic logic [XLEN:0] model();
    logic [IW-1:0] r;
    logic act, en, inv, zb, pred;
    logic [IW-1:0] pi;
    r   = req_cbranch ? 5'd0 : req_reg;
    act = req_is_fp ? ftab_active[r] : itab_active[r];
    en  = req_is_fp ? fpred_en[r]    : ipred_en[r];
    inv = req_is_fp ? fpred_inv[r]   : ipred_inv[r];
    zb  = req_is_fp ? fpred_zero[r]  : ipred_zero[r];
    pi  = req_is_fp ? fpred_idx[r*IW +: IW] : ipred_idx[r*IW +: IW];
    pred = en && (act || req_branch || req_cbranch);
    if (!pred) return {1'b0, {XLEN{1'b1}}};
    return {zb, inv ? ~rf[pi] : rf[pi]};
  endfunction

  task automatic check_out(string tag);
    logic [XLEN:0] e;
    e = model();
    total++;
    if (rsp_mask !== e[XLEN-1:0] || rsp_zero !== e[XLEN]) begin
      bad++;
      $display("FAIL %s: mask=%h zero=%b expected mask=%h zero=%b",
               tag, rsp_mask, rsp_zero, e[XLEN-1:0], e[XLEN]);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_addr(string tag, logic [IW-1:0] exp);
    total++;
    if (rf_raddr !== exp) begin
      bad++;
      $display("FAIL %s: raddr=%0d expected %0d", tag, rf_raddr, exp);
    end
  endtask

  task automatic clear_tables();
    itab_active = '0; ftab_active = '0;
    ipred_en = '0; ipred_inv = '0; ipred_zero = '0; ipred_idx = '0;
    fpred_en = '0; fpred_inv = '0; fpred_zero = '0; fpred_idx = '0;
    req_branch = 1'b0; req_cbranch = 1'b0; req_is_fp = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    req_valid = 1'b0; rsp_ready = 1'b0; req_reg = '0;
    clear_tables();
    for (int i = 0; i < NREG; i++) rf[i] = {$urandom(), $urandom()};
    settle();
    // R9: reset state, no request
    check_bit("R9 reset rsp_valid", rsp_valid, 1'b0);
    check_bit("R9 reset req_ready", req_ready, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1; rsp_ready = 1'b1;

    // R2: register table off, predicate entry fully on
    req_reg = 5'd3; ipred_en[3] = 1'b1; ipred_zero[3] = 1'b1; ipred_idx[3*IW +: IW] = 5'd7;
    settle();
    check_out("R2 reg inactive");
    check_bit("R2 zero low", rsp_zero, 1'b0);

    // R3: register table on, predicate off
    itab_active[3] = 1'b1; ipred_en[3] = 1'b0;
    settle();
    check_out("R3 pred disabled");
    check_bit("R3 mask all ones", &rsp_mask, 1'b1);

    // R4 and R6: both on, zeroing bit set
    ipred_en[3] = 1'b1; rf[7] = 64'h0123_4567_89ab_cdef;
    settle();
    check_addr("R4 raddr", 5'd7);
    check_out("R4 fetched mask");
    check_bit("R6 zero follows entry", rsp_zero, 1'b1);

    // R5: inversion
    ipred_inv[3] = 1'b1;
    settle();
    check_out("R5 inverted mask");

    // R1: floating-point tables used, integer tables differ
    clear_tables();
    req_reg = 5'd10; req_is_fp = 1'b1;
    ftab_active[10] = 1'b1; fpred_en[10] = 1'b1; fpred_idx[10*IW +: IW] = 5'd9;
    ipred_en[10] = 1'b1; itab_active[10] = 1'b1; ipred_idx[10*IW +: IW] = 5'd2;
    settle();
    check_addr("R1 fp raddr", 5'd9);
    check_out("R1 fp select");
    req_is_fp = 1'b0;
    settle();
    check_addr("R1 int raddr", 5'd2);
    check_out("R1 int select");

    // R7: branch skips the register-table check
    clear_tables();
    req_reg = 5'd20; ipred_en[20] = 1'b1; ipred_idx[20*IW +: IW] = 5'd11;
    settle();
    check_out("R7 non-branch baseline");
    req_branch = 1'b1;
    settle();
    check_addr("R7 branch raddr", 5'd11);
    check_out("R7 branch predicated");

    // R8: compressed branch takes register 0's entry
    clear_tables();
    req_reg = 5'd12; req_cbranch = 1'b1;
    ipred_en[12] = 1'b0; ipred_en[0] = 1'b1; ipred_idx[0 +: IW] = 5'd4; ipred_zero[0] = 1'b1;
    settle();
    check_addr("R8 cbranch raddr", 5'd4);
    check_out("R8 cbranch x0 entry");

    // R9: handshake passthrough
    rsp_ready = 1'b0;
    settle();
    check_bit("R9 ready follows", req_ready, 1'b0);
    req_valid = 1'b0;
    settle();
    check_bit("R9 valid follows", rsp_valid, 1'b0);
    req_valid = 1'b1; rsp_ready = 1'b1;

    // Random mix over R1..R8
    for (int n = 0; n < 400; n++) begin
      itab_active = $urandom(); ftab_active = $urandom();
      ipred_en = $urandom(); ipred_inv = $urandom(); ipred_zero = $urandom();
      fpred_en = $urandom(); fpred_inv = $urandom(); fpred_zero = $urandom();
      for (int e = 0; e < NREG; e++) begin
        ipred_idx[e*IW +: IW] = IW'($urandom());
        fpred_idx[e*IW +: IW] = IW'($urandom());
      end
      for (int i = 0; i < NREG; i++) rf[i] = {$urandom(), $urandom()};
      req_reg = IW'($urandom()); req_is_fp = 1'($urandom());
      req_branch = ($urandom() % 4) == 0;
      req_cbranch = ($urandom() % 6) == 0;
      settle();
      check_out("R4 random lookup");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule